// File: doc/BRIEF.md
# Interrupt Moderation Timer

This block sits between a network MAC's per-packet completion events and the interrupt status logic. It thins out the interrupt rate. Each of the two directions, transmit and receive, has its own path that works on its own. A path counts completion events and emits one interrupt pulse in either of two cases: the gathered events reach a programmed count, or a programmed delay runs out after the first pending event.

The delay is measured in cycle units. A unit is built from a bit-time tick, so it scales with link speed. The tick pulses once per bit time: every 10 ns at 100 Mb/s and every 100 ns at 10 Mb/s. A normal unit is 512 ticks, which gives 5.12 us or 51.2 us. A long unit is 8192 ticks, which gives 81.92 us or 819.2 us. The delay field is a multiple of the selected unit. When the count field is 1 and the delay field is 0, every event is reported at once.

The interrupt status and mask registers lie outside this block.

Top module: `irq_moderator`

## Requirements
- R1: While reset is held, and right after it is released, both interrupt outputs are low and both pending counts are empty. A single event with count field 2 and delay field 0 therefore raises no interrupt.
- R2: With delay field 0, the interrupt pulse goes high on the clock edge that samples the event bringing the pending count up to the count field. The pulse lasts one cycle. Fewer events raise nothing.
- R3: A count field of 0 behaves exactly like a count field of 1.
- R4: With count field 1, every event raises its own pulse on the edge that samples it. Events on consecutive edges give pulses on consecutive cycles.
- R5: With a nonzero delay field N and normal units, a pending event below the count raises the interrupt on the N*NORM_TICKS-th tick edge after the edge that sampled the first event. Ticks are counted from the following edge on.
- R6: With the long-unit select set to 1, one unit is LONG_TICKS ticks instead of NORM_TICKS ticks.
- R7: A delay field of 0 disables the timeout. Pending events below the count then never raise an interrupt.
- R8: Issuing an interrupt empties the pending count and clears the timer. The next interrupt needs a full count again, or a full delay measured from the next event.
- R9: The timer starts only when an event arrives while the count is empty. Later events in the same batch do not restart it.
- R10: The timer advances only on cycles where bit_tick is high.
- R11: If the count is reached and the delay runs out on the same edge, exactly one one-cycle pulse is issued and both the count and the timer are cleared.
- R12: The transmit and receive paths are independent. Events and settings on one path never cause a pulse on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_tick | input | 1 | One pulse per link bit time; this is the time base for delay units |
| tx_event | input | 1 | Transmit completion event, one per cycle at most |
| tx_thr | input | 3 | Transmit events per interrupt (0 means 1) |
| tx_tmo | input | 4 | Transmit delay in units (0 disables the timeout) |
| tx_long | input | 1 | Transmit unit select: 0 selects normal units, 1 selects long units |
| rx_event | input | 1 | Receive completion event, one per cycle at most |
| rx_thr | input | 3 | Receive events per interrupt (0 means 1) |
| rx_tmo | input | 4 | Receive delay in units (0 disables the timeout) |
| rx_long | input | 1 | Receive unit select: 0 selects normal units, 1 selects long units |
| tx_irq | output | 1 | Moderated transmit interrupt pulse |
| rx_irq | output | 1 | Moderated receive interrupt pulse |

## Verification
The count rule and the delay rule can both complete on the same edge. The bench sets count 3 and a one-unit delay, then places the third event exactly on the edge where the delay runs out. It then requires a single pulse on that edge and silence for the rest of a long window. Silence shows that neither rule leaves residue behind to fire a second time. Pulse positions are also compared for different count values, unit lengths, gated tick patterns and the cross-path case.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
  parameter int THR_W  = 3;
  parameter int TMO_W  = 4;
  parameter int NPATHS = 2;

  localparam int PATH_TX = 0;
  localparam int PATH_RX = 1;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic [TMO_W-1:0] tmo;
    logic             long_unit;
  } path_cfg_t;
endpackage

// File: rtl/imt_event_count.sv
module imt_event_count
  import irq_mod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [THR_W-1:0] thr,
  input  logic             clr,
  output logic             thr_hit,
  output logic             pending
);
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic [THR_W:0]   cnt_inc, thr_eff;
  logic             cnt_en;

  always_comb begin
    thr_eff = (thr == '0) ? (THR_W+1)'(1) : {1'b0, thr};
    cnt_inc = {1'b0, cnt_q} + (THR_W+1)'(1);
    thr_hit = evt && (cnt_inc >= thr_eff);
    cnt_en  = clr || evt;
    cnt_d   = cnt_q;
    if (clr)      cnt_d = '0;
    else if (evt) cnt_d = cnt_inc[THR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pending = (cnt_q != '0);
endmodule

// File: rtl/imt_unit_timer.sv
module imt_unit_timer
  import irq_mod_pkg::*;
#(
  parameter int NORM_TICKS = 512,
  parameter int LONG_TICKS = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             bit_tick,
  input  logic             long_unit,
  input  logic [TMO_W-1:0] tmo,
  output logic             expire
);
  localparam int MAX_TICKS = (LONG_TICKS > NORM_TICKS) ? LONG_TICKS : NORM_TICKS;
  localparam int TICK_W    = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;
  localparam logic [TICK_W-1:0] NORM_LAST = TICK_W'(NORM_TICKS - 1);
  localparam logic [TICK_W-1:0] LONG_LAST = TICK_W'(LONG_TICKS - 1);

  logic [TICK_W-1:0] tick_q, tick_d, unit_last;
  logic [TMO_W-1:0]  unit_q, unit_d;
  logic [TMO_W:0]    unit_inc;
  logic              unit_end, tmr_en;

  always_comb begin
    unit_last = long_unit ? LONG_LAST : NORM_LAST;
    unit_end  = run && bit_tick && (tick_q >= unit_last);
    unit_inc  = {1'b0, unit_q} + (TMO_W+1)'(1);
    expire    = unit_end && (tmo != '0) && (unit_inc >= {1'b0, tmo});
    tmr_en    = !run || clr || bit_tick;
    tick_d    = tick_q;
    unit_d    = unit_q;
    if (!run || clr) begin
      tick_d = '0;
      unit_d = '0;
    end else if (bit_tick) begin
      if (unit_end) begin
        tick_d = '0;
        unit_d = unit_inc[TMO_W-1:0];
      end else begin
        tick_d = tick_q + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      unit_q <= '0;
    end else if (tmr_en) begin
      tick_q <= tick_d;
      unit_q <= unit_d;
    end
  end
endmodule

// File: rtl/imt_path.sv
module imt_path
  import irq_mod_pkg::*;
#(
  parameter int NORM_TICKS = 512,
  parameter int LONG_TICKS = 8192
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_tick,
  input  logic      evt,
  input  path_cfg_t cfg,
  output logic      irq
);
  logic thr_hit, pending, expire, fire, irq_q;

  imt_event_count u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .thr     (cfg.thr),
    .clr     (fire),
    .thr_hit (thr_hit),
    .pending (pending)
  );

  imt_unit_timer #(
    .NORM_TICKS (NORM_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (pending),
    .clr       (fire),
    .bit_tick  (bit_tick),
    .long_unit (cfg.long_unit),
    .tmo       (cfg.tmo),
    .expire    (expire)
  );

  assign fire = thr_hit || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fire;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_mod_pkg::*;
#(
  parameter int NORM_TICKS = 512,
  parameter int LONG_TICKS = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_event,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [TMO_W-1:0] tx_tmo,
  input  logic             tx_long,
  input  logic             rx_event,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [TMO_W-1:0] rx_tmo,
  input  logic             rx_long,
  output logic             tx_irq,
  output logic             rx_irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_ok;
  path_cfg_t        cfg [NPATHS];
  logic [NPATHS-1:0] evt, irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  assign cfg[PATH_TX] = '{thr: tx_thr, tmo: tx_tmo, long_unit: tx_long};
  assign cfg[PATH_RX] = '{thr: rx_thr, tmo: rx_tmo, long_unit: rx_long};
  assign evt[PATH_TX] = tx_event;
  assign evt[PATH_RX] = rx_event;

  for (genvar g = 0; g < NPATHS; g++) begin : g_path
    imt_path #(
      .NORM_TICKS (NORM_TICKS),
      .LONG_TICKS (LONG_TICKS)
    ) u_path (
      .clk      (clk),
      .rst_n    (rst_ok),
      .bit_tick (bit_tick),
      .evt      (evt[g]),
      .cfg      (cfg[g]),
      .irq      (irq[g])
    );
  end

  assign tx_irq = irq[PATH_TX];
  assign rx_irq = irq[PATH_RX];
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk
  import irq_mod_pkg::*;
(
  input logic             clk,
  input logic             rst_ok,
  input logic             tx_event,
  input logic [THR_W-1:0] tx_thr,
  input logic [TMO_W-1:0] tx_tmo,
  input logic             rx_event,
  input logic [THR_W-1:0] rx_thr,
  input logic [TMO_W-1:0] rx_tmo,
  input logic             tx_irq,
  input logic             rx_irq
);
  logic [1:0]       ev, iq;
  logic [THR_W-1:0] thr [2];
  logic [TMO_W-1:0] tmo [2];

  assign ev     = {rx_event, tx_event};
  assign iq     = {rx_irq, tx_irq};
  assign thr[0] = tx_thr;
  assign thr[1] = rx_thr;
  assign tmo[0] = tx_tmo;
  assign tmo[1] = rx_tmo;

  always @(posedge clk) begin
    if (!rst_ok) AST_RESET_QUIET: assert (!tx_irq && !rx_irq); // R1
  end

  for (genvar p = 0; p < 2; p++) begin : g_chk
    logic [THR_W-1:0] shadow_q;
    logic             tmo_seen_q;
    logic [THR_W:0]   eff, nxt;

    assign eff = (thr[p] == '0) ? (THR_W+1)'(1) : {1'b0, thr[p]};
    assign nxt = {1'b0, shadow_q} + (THR_W+1)'(1);

    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) begin
        shadow_q   <= '0;
        tmo_seen_q <= 1'b0;
      end else begin
        if (tmo[p] != '0) tmo_seen_q <= 1'b1;
        if (ev[p]) shadow_q <= (nxt >= eff) ? '0 : nxt[THR_W-1:0];
      end
    end

    AST_THR_ONE_FIRES: assert property (@(posedge clk) disable iff (!rst_ok)
      (ev[p] && thr[p] <= THR_W'(1)) |=> iq[p]); // R3

    AST_NO_TMO_NO_EVT: assert property (@(posedge clk) disable iff (!rst_ok)
      (tmo[p] == '0 && !ev[p]) |=> !iq[p]); // R7

    AST_COUNT_REACHED: assert property (@(posedge clk) disable iff (!rst_ok)
      (!tmo_seen_q && tmo[p] == '0 && ev[p] && nxt >= eff) |=> iq[p]); // R2

    AST_COUNT_SHORT: assert property (@(posedge clk) disable iff (!rst_ok)
      (!tmo_seen_q && tmo[p] == '0 && ev[p] && nxt < eff) |=> !iq[p]); // R8
  end
endmodule

bind irq_moderator irq_moderator_chk u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .tx_event (tx_event),
  .tx_thr   (tx_thr),
  .tx_tmo   (tx_tmo),
  .rx_event (rx_event),
  .rx_thr   (rx_thr),
  .rx_tmo   (rx_tmo),
  .tx_irq   (tx_irq),
  .rx_irq   (rx_irq)
);

// File: tb/irq_moderator_tb.sv
`timescale 1ns/1ps
module irq_moderator_tb;
  localparam int NT = 4;
  localparam int LT = 16;
  localparam int NV = 9;
  localparam int WIN = 300;
  // columns: thr, tmo, long, events on edges 0..n-1, expected first irq edge (-1 none)
  localparam int VEC [NV][5] = '{
    '{1, 0, 0, 1, 0},
    '{0, 0, 0, 1, 0},
    '{3, 0, 0, 3, 2},
    '{7, 0, 0, 7, 6},
    '{4, 0, 0, 2, -1},
    '{4, 2, 0, 1, 2*NT},
    '{4, 1, 1, 1, LT},
    '{5, 3, 0, 3, 3*NT},
    '{2, 15, 1, 2, 1}
  };

  logic clk = 1'b0;
  logic rst_n, bit_tick;
  logic tx_event, tx_long, rx_event, rx_long;
  logic [2:0] tx_thr, rx_thr;
  logic [3:0] tx_tmo, rx_tmo;
  logic tx_irq, rx_irq;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  irq_moderator #(.NORM_TICKS(NT), .LONG_TICKS(LT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .tx_event(tx_event), .tx_thr(tx_thr), .tx_tmo(tx_tmo), .tx_long(tx_long),
    .rx_event(rx_event), .rx_thr(rx_thr), .rx_tmo(rx_tmo), .rx_long(rx_long),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic string vreq(input int i);
    case (i)
      0: vreq = "R4";
      1: vreq = "R3";
      2, 3: vreq = "R2";
      4: vreq = "R7";
      5: vreq = "R5";
      6: vreq = "R6";
      7: vreq = "R9";
      default: vreq = "R2";
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_event = 0; rx_event = 0; bit_tick = 1'b1;
    tx_thr = 0; tx_tmo = 0; tx_long = 0; rx_thr = 0; rx_tmo = 0; rx_long = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_masks(input logic [63:0] txm, input logic [63:0] rxm, input int n,
                           input bit tick_alt, output logic [63:0] txl, output logic [63:0] rxl);
    txl = '0; rxl = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tx_event = txm[k];
      rx_event = rxm[k];
      bit_tick = tick_alt ? k[0] : 1'b1;
      @(posedge clk); #1;
      txl[k] = tx_irq;
      rxl[k] = rx_irq;
    end
    @(negedge clk);
    tx_event = 0; rx_event = 0; bit_tick = 1'b1;
  endtask

  initial begin
    logic [63:0] tl, rl;
    int first, rxhit;
    do_reset();
    // R1: reset state
    check("R1 tx_irq after reset", tx_irq, 0);
    check("R1 rx_irq after reset", rx_irq, 0);

    // vector table walk on the transmit path
    for (int v = 0; v < NV; v++) begin
      do_reset();
      tx_thr = 3'(VEC[v][0]); tx_tmo = 4'(VEC[v][1]); tx_long = VEC[v][2][0];
      rx_thr = 3'd1;
      first = -1; rxhit = 0;
      for (int k = 0; k < WIN; k++) begin
        @(negedge clk);
        tx_event = (k < VEC[v][3]);
        @(posedge clk); #1;
        if (tx_irq && first < 0) first = k;
        if (rx_irq) rxhit = 1;
      end
      tx_event = 0;
      check(vreq(v), first, VEC[v][4]);
      check("R12 rx quiet", rxhit, 0);
    end

    // R1: count starts empty; one event with thr 2 waits for the second
    do_reset(); tx_thr = 2;
    run_masks(64'h1 | (64'h1 << 20), 64'h0, 40, 0, tl, rl);
    check("R1 empty count after reset", tl, 64'h1 << 20);

    // R4: back-to-back events give back-to-back pulses
    do_reset(); tx_thr = 1;
    run_masks(64'h7, 64'h0, 10, 0, tl, rl);
    check("R4 back-to-back", tl, 64'h7);

    // R8: count cleared by interrupt
    do_reset(); tx_thr = 3;
    run_masks(64'h267, 64'h0, 20, 0, tl, rl);
    check("R8 count restarts", tl, (64'h1 << 2) | (64'h1 << 9));

    // R8: timer cleared by interrupt
    do_reset(); tx_thr = 4; tx_tmo = 2;
    run_masks(64'h1 | (64'h1 << 10), 64'h0, 30, 0, tl, rl);
    check("R8 timer restarts", tl, (64'h1 << 8) | (64'h1 << 18));

    // R10: timer advances only on tick cycles
    do_reset(); tx_thr = 4; tx_tmo = 1;
    run_masks(64'h1, 64'h0, 20, 1, tl, rl);
    check("R10 gated ticks", tl, 64'h1 << 7);

    // R11: count and timeout complete on the same edge
    do_reset(); tx_thr = 3; tx_tmo = 1;
    run_masks(64'h13, 64'h0, 40, 0, tl, rl);
    check("R11 single pulse", tl, 64'h1 << 4);

    // R12: paths independent
    do_reset(); tx_thr = 1; rx_thr = 2;
    run_masks(64'h1, 64'h18, 10, 0, tl, rl);
    check("R12 tx only own event", tl, 64'h1);
    check("R12 rx only own events", rl, 64'h1 << 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule